// File: doc/BRIEF.md
# Masked Event Interrupt Controller

This block collects thirteen single-cycle event pulses from a network controller's transmit and receive engines into one 32-bit event register, with a 32-bit mask register beside it. The thirteen event bits sit in the top of the word, from bit 31 down to bit 19. Software reads both registers through a simple register port. It clears events by writing ones to the event register and sets the mask by writing the whole word. Each of thirteen interrupt lines is the AND of one event bit and its mask bit. The lines are registered and follow a fixed order that does not match bit order.

The register port also holds a transmit control word. Writing it with bit 0 set is a graceful-stop request. The transmitter is treated as already idle, so the graceful-stop-complete event is raised on the same clock edge as the write. A synchronous soft reset input returns the event, mask and control registers to zero.

Top module: `evt_irq_ctrl`

## Requirements
- R1: Event bit positions are heartbeat 31, babbling-rx 30, babbling-tx 29, graceful-stop-complete 28, tx-frame 27, tx-buffer 26, rx-frame 25, rx-buffer 24, MII 23, bus-error 22, late-collision 21, retry-limit 20, underrun 19. A one on `hw_evt_i[k]` at a clock edge sets event bit 19+k at that edge.
- R2: A write to address 0x0 (event register) clears each event bit written as one and leaves bits written as zero unchanged.
- R3: When a hardware set and a software clear hit the same event bit on one edge, the bit ends up set.
- R4: A write to address 0x1 replaces all 32 bits of the mask register, and a read of 0x1 returns that value.
- R5: Interrupt line outputs are registered. A line is high exactly when, one clock earlier, both its event bit and the mask bit at the same position were set.
- R6: `irq_o[0..12]` carry, in order: tx-frame, tx-buffer, underrun, retry-limit, rx-frame, rx-buffer, MII, late-collision, heartbeat, graceful-stop-complete, bus-error, babbling-tx, babbling-rx.
- R7: A write to address 0x2 stores the transmit control word, which reads back at 0x2. If bit 0 of the written word is one, event bit 28 is set on the same edge. If bit 0 is zero, the event is unchanged.
- R8: `soft_rst_i` high at an edge clears the event, mask and control registers, and it takes priority over hardware sets on that edge.
- R9: Event bits 18 to 0 always read as zero and no write changes them. Reads of other addresses return zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Synchronous soft reset of all registers |
| hw_evt_i | input | 13 | Event set pulses; bit k sets event bit 19+k |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 13 | Registered interrupt lines in the R6 order |

## Verification
A wrong event bit shows on the read port right after the edge that should have changed it. It shows on the interrupt line one clock later, once that line is unmasked. A broken line permutation stays hidden while everything is masked, so the bench drives each event alone with the full mask on and checks which line rises. The clear and set priority, the control-word side effect and soft reset precedence each fix one bit's value at a single edge. A fault in any of them shows as a one-bit difference on the next read.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned EVT_NUM = 13;
  localparam int unsigned EVT_LSB = DATA_W - EVT_NUM;

  localparam logic [ADDR_W-1:0] ADR_EVENT = 4'h0;
  localparam logic [ADDR_W-1:0] ADR_MASK  = 4'h1;
  localparam logic [ADDR_W-1:0] ADR_TXCTL = 4'h2;

  // event indices relative to EVT_LSB
  localparam int unsigned EV_UNDERRUN = 0;
  localparam int unsigned EV_RETRY    = 1;
  localparam int unsigned EV_LATECOL  = 2;
  localparam int unsigned EV_BUSERR   = 3;
  localparam int unsigned EV_MII      = 4;
  localparam int unsigned EV_RXBUF    = 5;
  localparam int unsigned EV_RXFRM    = 6;
  localparam int unsigned EV_TXBUF    = 7;
  localparam int unsigned EV_TXFRM    = 8;
  localparam int unsigned EV_GSTOP    = 9;
  localparam int unsigned EV_BABTX    = 10;
  localparam int unsigned EV_BABRX    = 11;
  localparam int unsigned EV_HEART    = 12;

  // which event index feeds a given interrupt line
  function automatic int unsigned line_src(input int unsigned line);
    case (line)
      0:       return EV_TXFRM;
      1:       return EV_TXBUF;
      2:       return EV_UNDERRUN;
      3:       return EV_RETRY;
      4:       return EV_RXFRM;
      5:       return EV_RXBUF;
      6:       return EV_MII;
      7:       return EV_LATECOL;
      8:       return EV_HEART;
      9:       return EV_GSTOP;
      10:      return EV_BUSERR;
      11:      return EV_BABTX;
      default: return EV_BABRX;
    endcase
  endfunction

  // next event state: clear first, then OR in sets so sets win
  function automatic logic [EVT_NUM-1:0] evt_next(
    input logic [EVT_NUM-1:0] cur,
    input logic [EVT_NUM-1:0] clr,
    input logic [EVT_NUM-1:0] set
  );
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/evt_irq_regport.sv
module evt_irq_regport
  import evt_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NE = EVT_NUM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NE-1:0] evt_q,
  input  logic [DW-1:0] mask_q,
  output logic          evt_clr_we,
  output logic [NE-1:0] evt_clr_bits,
  output logic          mask_we,
  output logic          gstop_req,
  output logic [DW-1:0] rdata
);
  localparam int unsigned LSB = DW - NE;

  logic          txctl_we;
  logic [DW-1:0] txctl_q;

  always_comb begin
    evt_clr_we   = wr && (addr == ADR_EVENT);
    mask_we      = wr && (addr == ADR_MASK);
    txctl_we     = wr && (addr == ADR_TXCTL);
    evt_clr_bits = wdata[DW-1:LSB];
    gstop_req    = txctl_we && wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        txctl_q <= '0;
    else if (soft_rst) txctl_q <= '0;
    else if (txctl_we) txctl_q <= wdata;
  end

  always_comb begin
    case (addr)
      ADR_EVENT: rdata = {evt_q, {LSB{1'b0}}};
      ADR_MASK:  rdata = mask_q;
      ADR_TXCTL: rdata = txctl_q;
      default:   rdata = '0;
    endcase
  end

  AST_TXCTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!txctl_we && !soft_rst) |=> $stable(txctl_q)); // R9
  AST_TXCTL_SOFT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (txctl_q == '0)); // R8
endmodule

// File: rtl/evt_irq_status.sv
module evt_irq_status
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = EVT_NUM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic [NE-1:0] set_vec,
  input  logic          clr_we,
  input  logic [NE-1:0] clr_bits,
  output logic [NE-1:0] evt_q
);
  logic [NE-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        evt_q <= '0;
    else if (soft_rst) evt_q <= '0;
    else               evt_q <= evt_next(evt_q, clr_eff, set_vec);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> ((evt_q & $past(set_vec)) == $past(set_vec))); // R3
  AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !soft_rst) |=> ((evt_q & $past(clr_bits) & ~$past(set_vec)) == '0)); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((evt_q & ~$past(evt_q) & ~$past(set_vec)) == '0)); // R1
  AST_SOFT_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (evt_q == '0)); // R8
endmodule

// File: rtl/evt_irq_mask.sv
module evt_irq_mask
  import evt_irq_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        mask_q <= '0;
    else if (soft_rst) mask_q <= '0;
    else if (we)       mask_q <= wdata;
  end

  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !soft_rst) |=> (mask_q == $past(wdata))); // R4
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!we && !soft_rst) |=> $stable(mask_q)); // R4
endmodule

// File: rtl/evt_irq_route.sv
module evt_irq_route
  import evt_irq_pkg::*;
#(
  parameter int unsigned NE = EVT_NUM
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NE-1:0] evt_q,
  input  logic [NE-1:0] mask_bits,
  output logic [NE-1:0] irq_q
);
  logic [NE-1:0] active;

  assign active = evt_q & mask_bits;

  for (genvar ln = 0; ln < NE; ln++) begin : g_line
    localparam int unsigned SRC = line_src(ln);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q[ln] <= 1'b0;
      else        irq_q[ln] <= active[SRC];
    end
    AST_LINE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq_q[ln] == $past(evt_q[SRC] && mask_bits[SRC]))); // R5 R6
  end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
  import evt_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               soft_rst_i,
  input  logic [EVT_NUM-1:0] hw_evt_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic [EVT_NUM-1:0] irq_o
);
  logic [EVT_NUM-1:0] evt_q;
  logic [DATA_W-1:0]  mask_q;
  logic               evt_clr_we;
  logic [EVT_NUM-1:0] evt_clr_bits;
  logic               mask_we;
  logic               gstop_req;
  logic [EVT_NUM-1:0] set_vec;

  assign set_vec = hw_evt_i | (EVT_NUM'(gstop_req) << EV_GSTOP);

  evt_irq_regport u_port (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i),
    .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i),
    .evt_q(evt_q), .mask_q(mask_q),
    .evt_clr_we(evt_clr_we), .evt_clr_bits(evt_clr_bits),
    .mask_we(mask_we), .gstop_req(gstop_req), .rdata(reg_rdata_o)
  );

  evt_irq_status u_status (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i),
    .set_vec(set_vec), .clr_we(evt_clr_we), .clr_bits(evt_clr_bits),
    .evt_q(evt_q)
  );

  evt_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst_i),
    .we(mask_we), .wdata(reg_wdata_i), .mask_q(mask_q)
  );

  evt_irq_route u_route (
    .clk(clk), .rst_n(rst_n), .evt_q(evt_q),
    .mask_bits(mask_q[DATA_W-1:EVT_LSB]), .irq_q(irq_o)
  );

  AST_GSTOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == ADR_TXCTL && reg_wdata_i[0] && !soft_rst_i)
    |=> evt_q[EV_GSTOP]); // R7

  always_comb begin
    if (rst_n && reg_addr_i == ADR_EVENT)
      AST_LOW_ZERO: assert (reg_rdata_o[EVT_LSB-1:0] == '0); // R9
  end
endmodule

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst_i = 1'b0;
  logic [12:0] hw_evt_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [3:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [12:0] irq_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] m_evt = '0;
  logic [31:0] m_mask = '0;
  int line_bit [13];

  always #10 clk = ~clk;

  evt_irq_ctrl dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [12:0] exp_irq(input logic [31:0] e, input logic [31:0] m);
    logic [12:0] r;
    for (int i = 0; i < 13; i++) r[i] = e[line_bit[i]] & m[line_bit[i]];
    return r;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr_i = a;
    #1;
    d = reg_rdata_o;
  endtask

  task automatic pulse(input logic [12:0] v);
    @(negedge clk);
    hw_evt_i = v;
    @(negedge clk);
    hw_evt_i = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(4'h0, d); check("R8 reset event", d, 32'h0);
    rd(4'h1, d); check("R8 reset mask", d, 32'h0);
    check("R5 reset irq", {19'h0, irq_o}, 32'h0);
  endtask

  task automatic t_bits_r1;
    logic [31:0] d;
    for (int k = 0; k < 13; k++) begin
      pulse(13'h1 << k);
      rd(4'h0, d);
      check("R1 event position", d, 32'h1 << (19 + k));
      wr(4'h0, 32'hFFFF_FFFF);
      rd(4'h0, d);
      check("R2 clear all", d, 32'h0);
    end
  endtask

  task automatic t_w1c_r2;
    logic [31:0] d;
    pulse(13'h1A5A);
    m_evt = 32'h1A5A << 19;
    wr(4'h0, 32'h0);
    rd(4'h0, d); check("R2 zero write keeps", d, m_evt);
    wr(4'h0, 32'h1200_0000 | (32'h0A00 << 19));
    m_evt = m_evt & ~(32'h1200_0000 | (32'h0A00 << 19));
    rd(4'h0, d); check("R2 partial clear", d, m_evt);
    wr(4'h0, 32'hFFFF_FFFF); m_evt = 0;
  endtask

  task automatic t_set_wins_r3;
    logic [31:0] d;
    @(negedge clk);
    hw_evt_i = 13'h0030;
    reg_wr_i = 1'b1; reg_addr_i = 4'h0; reg_wdata_i = 32'hFFFF_FFFF;
    @(negedge clk);
    hw_evt_i = '0; reg_wr_i = 1'b0;
    rd(4'h0, d); check("R3 set beats clear", d, 32'h0030 << 19);
    wr(4'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_mask_r4;
    logic [31:0] d;
    wr(4'h1, 32'hDEAD_BEEF); rd(4'h1, d); check("R4 mask readback", d, 32'hDEAD_BEEF);
    wr(4'h1, 32'h1234_5678); rd(4'h1, d); check("R4 mask overwrite", d, 32'h1234_5678);
    wr(4'h1, 32'h0);
  endtask

  task automatic t_route_r5_r6;
    wr(4'h1, 32'hFFFF_FFFF); m_mask = 32'hFFFF_FFFF;
    for (int k = 0; k < 13; k++) begin
      pulse(13'h1 << k);
      m_evt = 32'h1 << (19 + k);
      check("R5 irq one clock late", {19'h0, irq_o}, 32'h0);
      @(negedge clk);
      check("R6 line order", {19'h0, irq_o}, {19'h0, exp_irq(m_evt, m_mask)});
      wr(4'h0, 32'hFFFF_FFFF); m_evt = 0;
      @(negedge clk);
    end
    pulse(13'h1FFF); m_evt = 32'hFFF8_0000;
    wr(4'h1, 32'hA550_0000); m_mask = 32'hA550_0000;
    @(negedge clk);
    check("R5 masked lines", {19'h0, irq_o}, {19'h0, exp_irq(m_evt, m_mask)});
    wr(4'h1, 32'h0); m_mask = 0;
    @(negedge clk);
    check("R5 all masked", {19'h0, irq_o}, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF); m_evt = 0;
  endtask

  task automatic t_gstop_r7;
    logic [31:0] d;
    wr(4'h2, 32'h0000_0006);
    rd(4'h0, d); check("R7 no gstop when bit0 low", d, 32'h0);
    rd(4'h2, d); check("R7 control readback", d, 32'h0000_0006);
    wr(4'h2, 32'h0000_0001);
    rd(4'h0, d); check("R7 gstop event", d, 32'h1000_0000);
    wr(4'h0, 32'hFFFF_FFFF);
  endtask

  task automatic t_soft_r8;
    logic [31:0] d;
    wr(4'h1, 32'hFFFF_FFFF);
    wr(4'h2, 32'h5);
    pulse(13'h0F0F);
    @(negedge clk);
    soft_rst_i = 1'b1; hw_evt_i = 13'h1FFF;
    @(negedge clk);
    soft_rst_i = 1'b0; hw_evt_i = '0;
    rd(4'h0, d); check("R8 soft clears event", d, 32'h0);
    rd(4'h1, d); check("R8 soft clears mask", d, 32'h0);
    rd(4'h2, d); check("R8 soft clears control", d, 32'h0);
    @(negedge clk);
    check("R8 irq drops", {19'h0, irq_o}, 32'h0);
  endtask

  task automatic t_low_r9;
    logic [31:0] d;
    wr(4'h1, 32'h0000_00FF);
    pulse(13'h0003);
    wr(4'h0, 32'h0007_FFFF);
    rd(4'h0, d); check("R9 low write no effect", d, 32'h0018_0000);
    wr(4'h7, 32'hFFFF_FFFF);
    rd(4'h0, d); check("R9 unmapped write ignored evt", d, 32'h0018_0000);
    rd(4'h1, d); check("R9 unmapped write ignored mask", d, 32'h0000_00FF);
    rd(4'h7, d); check("R9 unmapped read zero", d, 32'h0);
    wr(4'h0, 32'hFFFF_FFFF); wr(4'h1, 32'h0);
  endtask

  initial begin
    line_bit = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_bits_r1;
    t_w1c_r2;
    t_set_wins_r3;
    t_mask_r4;
    t_route_r5_r6;
    t_gstop_r7;
    t_low_r9;
    t_soft_r8;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule